// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

The block turns frames arriving on one idle-high NRZ line into characters that a host reads over a 16-bit register bus. Every frame starts with a low start bit. Then come 1 to 8 data bits, least significant bit first. An optional address bit and an optional even or odd parity bit may follow, and the frame ends with one or two high stop bits. An internal baud generator produces a sample tick every `divisor + 1` clocks. The line is sampled eight times per bit, and each bit is decided by a 2-of-3 majority vote of the samples at positions 3, 4 and 5.

Each finished character moves into a holding buffer and raises a ready flag. The receiver can work on the next frame while the host has not yet read the buffer. Parity, overrun, framing and break conditions each have their own sticky flag, and a combined error flag is the OR of all four. When the sleep bit is set, two wake-up filters are available. In address-bit mode, only characters whose address bit is 1 are passed on. In idle-line mode, only a character that follows at least 10 bit times of idle line is passed on.

The receiver is a state machine with these states: `ST_IDLE`, `ST_START`, `ST_DATA`, `ST_ADDR`, `ST_PAR`, `ST_STOP1`, `ST_STOP2` and `ST_BREAK`. All transitions happen on a sample tick:

- `ST_IDLE`→`ST_START` when a low sample is seen.
- `ST_START`→`ST_IDLE` when the mid-bit vote is high (a false start); otherwise `ST_START`→`ST_DATA`.
- `ST_DATA`→`ST_ADDR`, `ST_PAR` or `ST_STOP1` after the last data bit, depending on the format.
- `ST_ADDR`→`ST_PAR` or `ST_STOP1`.
- `ST_PAR`→`ST_STOP1`.
- `ST_STOP1`→`ST_STOP2` when two stop bits are configured.
- From the last stop state, →`ST_BREAK` if a stop bit sampled low, otherwise →`ST_IDLE`.
- `ST_BREAK`→`ST_IDLE` when the line is high again.

Top module: `nrz_receiver`

Register map (address = `bus_addr`; every register is 8 bits in `bus_rdata[7:0]`):

| Address | Register | Access | Contents |
|---|---|---|---|
| 0 | Receive buffer | read | Last accepted character. Reading it clears the ready flag. |
| 1 | Status | read | Flag bits listed below. Reading it clears bits 1 to 4. |
| 2 | Control | read/write | Format and wake-up settings listed below. |
| 3 | Divisor low | read/write | Lower 8 bits of the 16-bit divisor. |
| 4 | Divisor high | read/write | Upper 8 bits of the 16-bit divisor. |

Status bits: 0 ready, 1 parity error, 2 overrun, 3 framing error, 4 break, 5 combined error, 6 address bit of the buffered character.

Control bits: [7:5] data length minus 1, 4 parity enable, 3 odd parity, 2 two stop bits, 1 address-bit mode (0 selects idle-line mode), 0 sleep.

## Requirements
- R1: After reset, the status register (address 1) and the buffer register (address 0) both read 0.
- R2: An 8-bit frame with no parity, sent least significant bit first, is placed in the buffer and sets status bit 0 (ready).
- R3: The data length is control[7:5]+1, and shorter characters are right-aligned in the buffer. When control bit 4 is set, a parity bit follows the data; it is even parity when control bit 3 is 0 and odd parity when it is 1. When control bit 2 is set, two stop bits are expected.
- R4: A parity mismatch sets status bit 1, and the character is still buffered. Status bit 5 is the OR of status bits 1 to 4.
- R5: Reading the buffer clears the ready flag. Reading the status register clears status bits 1 to 4.
- R6: A character that completes while ready is still set sets status bit 2 (overrun), and the buffer keeps the older character.
- R7: A low first stop bit sets status bit 3 (framing). Status bit 4 (break) is set only when the line then stays low for at least 10 more bit times.
- R8: When control bit 1 = 1 and control bit 0 = 1 (address-bit mode, asleep), a frame carries an address bit after the data. A frame whose address bit is 0 is dropped and leaves ready unchanged. A frame whose address bit is 1 is buffered, with that bit shown in status bit 6.
- R9: When control bit 1 = 0 and control bit 0 = 1 (idle-line mode, asleep), only a character whose start bit follows at least 10 bit times of high line is buffered. A character sent directly after it is dropped.
- R10: A low pulse shorter than half a bit time does not start a character.
- R11: Bits 15:8 of a read are always 0, and bits 15:8 of a write are ignored.
- R12: One bit time is 8 × (divisor + 1) clocks, where the divisor is {register 4, register 3}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_line | input | 1 | Serial receive line, high when idle |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data; only bits 7:0 are used |
| bus_rdata | output | 16 | Read data; bits 15:8 are always 0 |

## Verification
Clean frames are sent in three formats: 8N1, 5-bit even parity, and 7-bit odd parity with two stop bits. These show whether the bit count, the right alignment and the parity sense follow the control register. Frames with a flipped parity bit, with a low stop bit, and with a low stop bit followed by a long low hold separate the parity, framing and break flags from one another. Back-to-back frames with no read in between show overrun, and in sleep mode they show which characters the idle-line and address-bit filters let through. A short low glitch and a frame at a larger divisor check the start-bit confirmation and the bit-rate scaling.

// File: rtl/nrz_rx_pkg.sv
package nrz_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_ADDR,
        ST_PAR,
        ST_STOP1,
        ST_STOP2,
        ST_BREAK
    } rx_state_t;

    // Control register layout, MSB first
    typedef struct packed {
        logic [2:0] len_m1;
        logic       par_en;
        logic       par_odd;
        logic       two_stop;
        logic       addr_mode;
        logic       sleep;
    } rx_cfg_t;

    localparam logic [2:0] A_BUF   = 3'd0;
    localparam logic [2:0] A_STAT  = 3'd1;
    localparam logic [2:0] A_CTRL  = 3'd2;
    localparam logic [2:0] A_DIVLO = 3'd3;
    localparam logic [2:0] A_DIVHI = 3'd4;

endpackage

// File: rtl/nrz_rx_baud.sv
module nrz_rx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= divisor) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/nrz_rx_sampler.sv
module nrz_rx_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rx_line,
    output logic line_s,
    output logic vote
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic [2:0]             win_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            win_q  <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], rx_line};
            if (tick) win_q <= {win_q[1:0], sync_q[SYNC_STAGES-1]};
        end
    end

    assign line_s = sync_q[SYNC_STAGES-1];
    assign vote   = (win_q[0] & win_q[1]) | (win_q[0] & win_q[2]) | (win_q[1] & win_q[2]);
endmodule

// File: rtl/nrz_rx_fsm.sv
module nrz_rx_fsm
    import nrz_rx_pkg::*;
#(
    parameter int OVS       = 8,
    parameter int IDLE_BITS = 10
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      line_s,
    input  logic      vote,
    input  rx_cfg_t   cfg,
    output rx_state_t state,
    output logic      done_o,
    output logic      accept_o,
    output logic [7:0] data_o,
    output logic      abit_o,
    output logic      par_o,
    output logic      frm_o,
    output logic      brk_o
);
    localparam int PH_W       = $clog2(OVS);
    localparam int IDLE_TICKS = OVS * IDLE_BITS;
    localparam int CNT_W      = $clog2(IDLE_TICKS + 1);
    localparam logic [PH_W-1:0] PH_MID  = PH_W'(OVS / 2 + 2);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVS - 1);

    rx_state_t        nxt;
    logic [PH_W-1:0]  phase;
    logic             bitv, par_acc, perr, ferr, abit, idle_gate;
    logic [2:0]       bitcnt;
    logic [7:0]       shreg;
    logic [CNT_W-1:0] cnt;
    logic             last_stop;

    assign last_stop = (state == ST_STOP2) || !cfg.two_stop;

    // next-state logic
    always_comb begin
        nxt = state;
        if (tick) begin
            unique case (state)
                ST_IDLE:  if (!line_s) nxt = ST_START;
                ST_START: if (phase == PH_LAST) nxt = bitv ? ST_IDLE : ST_DATA;
                ST_DATA:  if (phase == PH_LAST && bitcnt == cfg.len_m1)
                              nxt = cfg.addr_mode ? ST_ADDR : (cfg.par_en ? ST_PAR : ST_STOP1);
                ST_ADDR:  if (phase == PH_LAST) nxt = cfg.par_en ? ST_PAR : ST_STOP1;
                ST_PAR:   if (phase == PH_LAST) nxt = ST_STOP1;
                ST_STOP1, ST_STOP2:
                          if (phase == PH_LAST) begin
                              if (!last_stop)        nxt = ST_STOP2;
                              else if (ferr || !bitv) nxt = ST_BREAK;
                              else                    nxt = ST_IDLE;
                          end
                ST_BREAK: if (line_s) nxt = ST_IDLE;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0; bitv <= 1'b1; par_acc <= 1'b0; perr <= 1'b0; ferr <= 1'b0;
            abit <= 1'b0; idle_gate <= 1'b0; bitcnt <= '0; shreg <= '0; cnt <= '0;
            done_o <= 1'b0; accept_o <= 1'b0; data_o <= '0; abit_o <= 1'b0;
            par_o <= 1'b0; frm_o <= 1'b0; brk_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            brk_o  <= 1'b0;
            if (tick) begin
                if (state == ST_IDLE) begin
                    if (!line_s) begin
                        phase     <= PH_W'(1);
                        idle_gate <= (cnt >= CNT_W'(IDLE_TICKS));
                        cnt       <= '0;
                    end else begin
                        phase <= '0;
                        if (cnt < CNT_W'(IDLE_TICKS)) cnt <= cnt + 1'b1;
                    end
                end else if (state == ST_BREAK) begin
                    if (line_s) cnt <= '0;
                    else if (cnt < CNT_W'(IDLE_TICKS)) begin
                        cnt <= cnt + 1'b1;
                        if (cnt == CNT_W'(IDLE_TICKS - 1)) brk_o <= 1'b1;
                    end
                end else begin
                    phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
                    if (phase == PH_MID) bitv <= vote;
                    if (phase == PH_LAST) begin
                        unique case (state)
                            ST_START: begin
                                bitcnt <= '0; par_acc <= 1'b0; perr <= 1'b0;
                                ferr <= 1'b0; abit <= 1'b0;
                            end
                            ST_DATA: begin
                                shreg   <= {bitv, shreg[7:1]};
                                par_acc <= par_acc ^ bitv;
                                bitcnt  <= bitcnt + 1'b1;
                            end
                            ST_ADDR: begin
                                abit    <= bitv;
                                par_acc <= par_acc ^ bitv;
                            end
                            ST_PAR:  perr <= par_acc ^ bitv ^ cfg.par_odd;
                            ST_STOP1, ST_STOP2: begin
                                if (!bitv) ferr <= 1'b1;
                                if (last_stop) begin
                                    done_o   <= 1'b1;
                                    data_o   <= shreg >> (3'd7 - cfg.len_m1);
                                    frm_o    <= ferr | !bitv;
                                    par_o    <= perr;
                                    abit_o   <= abit;
                                    accept_o <= !cfg.sleep || (cfg.addr_mode ? abit : idle_gate);
                                end
                            end
                            default: ;
                        endcase
                    end
                end
            end
        end
    end
endmodule

// File: rtl/nrz_receiver.sv
module nrz_receiver
    import nrz_rx_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int OVS         = 8,
    parameter int IDLE_BITS   = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_line,
    input  logic        bus_en,
    input  logic        bus_we,
    input  logic [2:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata
);
    logic [7:0] ctrl_q, div_lo_q, div_hi_q, buf_q;
    logic       rdy_q, par_q, ovr_q, frm_q, brk_q, abit_q, err_w;
    logic       tick, line_s, vote;
    logic       fsm_done, fsm_accept, fsm_abit, fsm_par, fsm_frm, fsm_brk;
    logic [7:0] fsm_data;
    rx_state_t  fsm_state;
    logic       rd, load;
    logic [7:0] rbyte;

    nrz_rx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n),
        .divisor(DIV_W'({div_hi_q, div_lo_q})), .tick(tick)
    );

    nrz_rx_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_samp (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx_line(rx_line),
        .line_s(line_s), .vote(vote)
    );

    nrz_rx_fsm #(.OVS(OVS), .IDLE_BITS(IDLE_BITS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .line_s(line_s), .vote(vote),
        .cfg(rx_cfg_t'(ctrl_q)), .state(fsm_state),
        .done_o(fsm_done), .accept_o(fsm_accept), .data_o(fsm_data),
        .abit_o(fsm_abit), .par_o(fsm_par), .frm_o(fsm_frm), .brk_o(fsm_brk)
    );

    assign rd    = bus_en && !bus_we;
    assign load  = fsm_done && fsm_accept;
    assign err_w = par_q | ovr_q | frm_q | brk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0; div_lo_q <= '0; div_hi_q <= '0; buf_q <= '0;
            rdy_q <= 1'b0; par_q <= 1'b0; ovr_q <= 1'b0; frm_q <= 1'b0;
            brk_q <= 1'b0; abit_q <= 1'b0;
        end else begin
            if (bus_en && bus_we) begin
                unique case (bus_addr)
                    A_CTRL:  ctrl_q   <= bus_wdata[7:0];
                    A_DIVLO: div_lo_q <= bus_wdata[7:0];
                    A_DIVHI: div_hi_q <= bus_wdata[7:0];
                    default: ;
                endcase
            end
            if (rd && bus_addr == A_STAT) begin
                par_q <= 1'b0; ovr_q <= 1'b0; frm_q <= 1'b0; brk_q <= 1'b0;
            end
            if (load) begin
                rdy_q <= 1'b1;
                if (fsm_par) par_q <= 1'b1;
                if (fsm_frm) frm_q <= 1'b1;
                if (rdy_q) ovr_q <= 1'b1;
                else begin
                    buf_q  <= fsm_data;
                    abit_q <= fsm_abit;
                end
            end else if (rd && bus_addr == A_BUF) begin
                rdy_q <= 1'b0;
            end
            if (fsm_brk) brk_q <= 1'b1;
        end
    end

    always_comb begin
        unique case (bus_addr)
            A_BUF:   rbyte = buf_q;
            A_STAT:  rbyte = {1'b0, abit_q, err_w, brk_q, frm_q, ovr_q, par_q, rdy_q};
            A_CTRL:  rbyte = ctrl_q;
            A_DIVLO: rbyte = div_lo_q;
            A_DIVHI: rbyte = div_hi_q;
            default: rbyte = 8'h00;
        endcase
        bus_rdata = {8'h00, rbyte};
    end
endmodule

// File: rtl/nrz_rx_chk.sv
module nrz_rx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_en,
    input logic        bus_we,
    input logic [2:0]  bus_addr,
    input logic [15:0] bus_rdata,
    input logic        line_s,
    input logic        fsm_done,
    input logic        fsm_accept,
    input logic        fsm_par,
    input logic        fsm_brk,
    input logic        rdy_q,
    input logic        ovr_q,
    input logic        par_q,
    input logic        err_w,
    input logic [7:0]  buf_q
);
    logic rd_buf, load;
    assign rd_buf = bus_en && !bus_we && bus_addr == 3'd0;
    assign load   = fsm_done && fsm_accept;

    a_r5_read_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_buf && !load) |=> !rdy_q);

    a_r6_overrun_keeps_buffer: assert property (@(posedge clk) disable iff (!rst_n)
        (load && rdy_q) |=> (buf_q == $past(buf_q)) && ovr_q);

    a_r4_parity_sets_error: assert property (@(posedge clk) disable iff (!rst_n)
        (load && fsm_par) |=> par_q && err_w);

    a_r8_discard_leaves_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_done && !fsm_accept && !rd_buf) |=> rdy_q == $past(rdy_q));

    a_r7_break_needs_low_line: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_brk |-> !line_s);

    a_r11_upper_byte_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[15:8] == 8'h00);
endmodule

bind nrz_receiver nrz_rx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .line_s(line_s),
    .fsm_done(fsm_done), .fsm_accept(fsm_accept), .fsm_par(fsm_par),
    .fsm_brk(fsm_brk), .rdy_q(rdy_q), .ovr_q(ovr_q), .par_q(par_q),
    .err_w(err_w), .buf_q(buf_q)
);

// File: tb/tb_nrz_receiver.sv
`timescale 1ns/1ps
module tb_nrz_receiver;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_line = 1'b1;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;

    always #10 clk = ~clk;   // 50 MHz

    nrz_receiver dut (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .bus_en(bus_en),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    int          checks = 0;
    int          fails  = 0;
    int          div_now = 1;
    bit          mon_on = 1'b0;
    bit          finished = 1'b0;
    logic [15:0] exp_q[$];   // {2'b0, status[6:1], data}

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic line_bits(input bit v, input int n);
        rx_line = v;
        repeat (n * 8 * (div_now + 1)) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input int nb, input bit pen, input bit podd,
                        input bit two, input bit amode, input bit ab,
                        input bit badp, input bit stoplow);
        bit p;
        p = podd ^ (amode & ab);
        line_bits(1'b0, 1);
        for (int i = 0; i < nb; i++) begin
            line_bits(d[i], 1);
            p ^= d[i];
        end
        if (amode) line_bits(ab, 1);
        if (pen) line_bits(p ^ badp, 1);
        line_bits(!stoplow, 1);
        if (two) line_bits(1'b1, 1);
        rx_line = 1'b1;
    endtask

    // driver side of the scoreboard: push expectation then drive the frame
    task automatic drive_expect(input logic [7:0] d, input int nb, input bit pen,
                                input bit podd, input bit two, input bit badp,
                                input bit stoplow);
        logic [7:0] m;
        logic [5:0] st;
        m  = d & 8'((1 << nb) - 1);
        st = {1'b0, (badp | stoplow), 1'b0, stoplow, 1'b0, badp};
        exp_q.push_back({2'b00, st, m});
        send(d, nb, pen, podd, two, 1'b0, 1'b0, badp, stoplow);
    endtask

    // monitor: pops and compares as characters appear
    initial begin
        logic [15:0] s, d, e;
        forever begin
            @(negedge clk);
            if (mon_on) begin
                bus_rd(3'd1, s);
                if (s[0]) begin
                    bus_rd(3'd0, d);
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R2", "unexpected character", d, 0);
                    end else begin
                        e = exp_q.pop_front();
                        chk(d[7:0] == e[7:0], "R2/R3 data", "buffer", d[7:0], e[7:0]);
                        chk(s[6:1] == e[13:8], "R4/R7 flags", "status[6:1]", s[6:1], e[13:8]);
                    end
                end
            end
        end
    end

    task automatic drain();
        wait (exp_q.size() == 0);
        repeat (20) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        bus_rd(3'd1, r); chk(r == 16'h0, "R1", "status after reset", r, 0);
        bus_rd(3'd0, r); chk(r == 16'h0, "R1", "buffer after reset", r, 0);

        // R11 upper byte ignored / reads zero
        bus_wr(3'd2, 16'hAB00 | 16'h00E0);
        bus_rd(3'd2, r); chk(r == 16'h00E0, "R11", "control readback", r, 16'h00E0);
        bus_wr(3'd3, 16'h7701);
        bus_rd(3'd3, r); chk(r == 16'h0001, "R11", "divisor low readback", r, 16'h0001);
        bus_wr(3'd4, 16'h5A00);
        bus_rd(3'd4, r); chk(r == 16'h0000, "R11", "divisor high readback", r, 0);
        div_now = 1;
        repeat (200) @(negedge clk);

        // R2 8N1 frames through the scoreboard
        mon_on = 1'b1;
        drive_expect(8'hA5, 8, 0, 0, 0, 0, 0);
        drive_expect(8'h3C, 8, 0, 0, 0, 0, 0);
        drain();

        // R3 5-bit even parity, then 7-bit odd parity with two stop bits
        mon_on = 1'b0; repeat (10) @(negedge clk);
        bus_wr(3'd2, 16'h0090);
        mon_on = 1'b1;
        drive_expect(8'h15, 5, 1, 0, 0, 0, 0);
        drain();
        mon_on = 1'b0; repeat (10) @(negedge clk);
        bus_wr(3'd2, 16'h00DC);
        mon_on = 1'b1;
        drive_expect(8'h4B, 7, 1, 1, 1, 0, 0);
        // R4 parity error, character still buffered
        drive_expect(8'h22, 7, 1, 1, 1, 1, 0);
        drain();

        // R7 framing without break
        mon_on = 1'b0; repeat (10) @(negedge clk);
        bus_wr(3'd2, 16'h00E0);
        mon_on = 1'b1;
        drive_expect(8'h81, 8, 0, 0, 0, 0, 1);
        drain();
        mon_on = 1'b0; repeat (10) @(negedge clk);

        // R6 overrun keeps first character
        send(8'h11, 8, 0, 0, 0, 0, 0, 0, 0);
        send(8'h22, 8, 0, 0, 0, 0, 0, 0, 0);
        repeat (10) @(negedge clk);
        bus_rd(3'd1, r); chk(r == 16'h0025, "R6", "status ready+overrun+error", r, 16'h0025);
        bus_rd(3'd0, r); chk(r == 16'h0011, "R6", "buffer keeps first", r, 16'h0011);
        // R5 both reads clear their flags
        bus_rd(3'd1, r); chk(r == 16'h0000, "R5", "status after reads", r, 0);

        // R7 break after long low line
        send(8'h00, 8, 0, 0, 0, 0, 0, 0, 1);
        line_bits(1'b0, 12);
        line_bits(1'b1, 2);
        bus_rd(3'd1, r); chk(r == 16'h0039, "R7", "status framing+break", r, 16'h0039);
        bus_rd(3'd0, r); chk(r == 16'h0000, "R7", "break character", r, 0);

        // R10 short glitch ignored
        rx_line = 1'b0; repeat (4) @(negedge clk); rx_line = 1'b1;
        repeat (300) @(negedge clk);
        bus_rd(3'd1, r); chk(r == 16'h0000, "R10", "status after glitch", r, 0);

        // R8 address-bit wake-up
        bus_wr(3'd2, 16'h00E3);
        send(8'h55, 8, 0, 0, 0, 1, 0, 0, 0);
        repeat (20) @(negedge clk);
        bus_rd(3'd1, r); chk(r == 16'h0000, "R8", "data frame dropped", r, 0);
        send(8'h66, 8, 0, 0, 0, 1, 1, 0, 0);
        repeat (20) @(negedge clk);
        bus_rd(3'd1, r); chk(r == 16'h0041, "R8", "address frame status", r, 16'h0041);
        bus_rd(3'd0, r); chk(r == 16'h0066, "R8", "address frame data", r, 16'h0066);

        // R9 idle-line wake-up
        bus_wr(3'd2, 16'h00E1);
        repeat (240) @(negedge clk);
        send(8'h77, 8, 0, 0, 0, 0, 0, 0, 0);
        send(8'h88, 8, 0, 0, 0, 0, 0, 0, 0);
        repeat (20) @(negedge clk);
        bus_rd(3'd1, r); chk(r == 16'h0001, "R9", "only first passed", r, 16'h0001);
        bus_rd(3'd0, r); chk(r == 16'h0077, "R9", "first after idle", r, 16'h0077);
        bus_rd(3'd1, r); chk(r == 16'h0000, "R9", "second dropped", r, 0);

        // R12 slower bit rate
        bus_wr(3'd2, 16'h00E0);
        bus_wr(3'd3, 16'h0003);
        div_now = 3;
        repeat (400) @(negedge clk);
        mon_on = 1'b1;
        drive_expect(8'hC3, 8, 0, 0, 0, 0, 0);
        drain();
        mon_on = 1'b0;
        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R12", "scoreboard empty", exp_q.size(), 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule